// File: doc/BRIEF.md
# Periodic Wake-up Timer

This block produces a timeout at a fixed rate and records it. The count source is one of two single-cycle enable strobes. One strobe comes from a slow always-on clock and the other from the bus clock. Each strobe of the chosen source advances the count by one tick. The period is set by a 16-bit reload value that the surrounding logic presents on an input. At each timeout the block sets a sticky flag in its 8-bit control/status register. That flag can drive an interrupt request.

The block can also send a waveform to an external pin. It shows either a narrow high pulse at the end of each period or a square clock whose period is twice the timeout period. Software reaches the register through a small register bus with an address, write data, a write strobe and read data. Read data is combinational.

Top module: `periodic_wakeup_timer`

## Requirements
- R1: After reset the control register reads 0x00, `irq_o` is 0 and `ext_wave_o` is 0. Bits 6 and 5 always read 0, even after a write of 1s to them. Field positions: bit 7 source select, bit 4 waveform select, bit 3 pin enable, bit 2 run, bit 1 interrupt enable, bit 0 timeout flag.
- R2: With source select = 0, only `auto_tick_i` advances the count. With source select = 1, only `bus_tick_i` advances it. The strobe that is not selected has no effect.
- R3: The source-select bit takes the written value only when run is 0 before the write and the same write leaves bit 2 at 0. Otherwise it keeps its value.
- R4: After run is set, the first timeout comes on the 2·(reload+1)-th selected tick. Timeouts then repeat every 2·(reload+1) ticks. Clearing run stops the count, and a later restart counts from the beginning.
- R5: A timeout sets the flag. Writing 1 to bit 0 clears the flag, and writing 0 to bit 0 leaves it unchanged.
- R6: When a timeout and a write of 1 to bit 0 fall in the same cycle, the flag ends up set.
- R7: `irq_o` is 1 exactly when interrupt enable and the flag are both 1.
- R8: With pin enable = 1, run = 1 and waveform select = 0, `ext_wave_o` goes high after each timeout. It stays high until the next selected tick, which gives a width of one tick.
- R9: With pin enable = 1, run = 1 and waveform select = 1, `ext_wave_o` toggles at each timeout and starts low each time run is set.
- R10: With pin enable = 0 or run = 0, `ext_wave_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| bus_addr_i | input | ADDR_W | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_we_i | input | 1 | Write strobe |
| bus_rdata_o | output | 8 | Read data, 0 unless the address hits the control register |
| reload_i | input | CNT_W | Period reload value |
| auto_tick_i | input | 1 | Tick strobe from the always-on clock |
| bus_tick_i | input | 1 | Tick strobe from the bus clock |
| irq_o | output | 1 | Interrupt request |
| ext_wave_o | output | 1 | External waveform |

## Verification
The bench checks the source-select lock in several ways: a write that starts the timer, a write that stops it, and a write to a running timer. A design that checked the lock against the new run value instead of the old one would let a stopping write change the source. The bench places a flag-clearing write in the same cycle as a timeout; a design that gave the clear priority would lose that event. It counts ticks on both sides of the first timeout for short and longer reload values, so an off-by-one half-period would show up. It also feeds strobes from the source that is not selected, which catches a merged or swapped source. On the pin, it checks that the pulse drops at the next tick and that the clock output starts low again after a restart.

// File: rtl/pwt_pkg.sv
package pwt_pkg;

    localparam int REG_W = 8;

    typedef struct packed {
        logic       src_sel;
        logic [1:0] unused;
        logic       wave_sel;
        logic       pin_en;
        logic       run;
        logic       irq_en;
        logic       flag;
    } pwt_ctrl_t;

    typedef enum logic {
        SRC_AUTO = 1'b0,
        SRC_BUS  = 1'b1
    } pwt_src_e;

    typedef enum logic {
        WAVE_PULSE = 1'b0,
        WAVE_CLOCK = 1'b1
    } pwt_wave_e;

    // Next register value for a bus write, with the source lock and W1C flag applied.
    function automatic pwt_ctrl_t pwt_apply_write(pwt_ctrl_t cur, logic [REG_W-1:0] wd);
        pwt_ctrl_t nxt;
        nxt          = cur;
        nxt.unused   = 2'b00;
        nxt.wave_sel = wd[4];
        nxt.pin_en   = wd[3];
        nxt.run      = wd[2];
        nxt.irq_en   = wd[1];
        if (!cur.run && !wd[2])
            nxt.src_sel = wd[7];
        if (wd[0])
            nxt.flag = 1'b0;
        return nxt;
    endfunction

endpackage

// File: rtl/pwt_regs.sv
module pwt_regs
    import pwt_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int CTRL_ADDR = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [REG_W-1:0]  wdata_i,
    input  logic              we_i,
    input  logic              timeout_i,
    output pwt_ctrl_t         ctrl_o,
    output logic [REG_W-1:0]  rdata_o,
    output logic              wr_hit_o
);

    localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(CTRL_ADDR);

    pwt_ctrl_t ctrl_q, ctrl_d;
    logic      addr_hit;

    assign addr_hit = (addr_i == HIT_ADDR);
    assign wr_hit_o = we_i && addr_hit;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_hit_o)
            ctrl_d = pwt_apply_write(ctrl_q, wdata_i);
        // A timeout outranks a same-cycle clear.
        if (timeout_i)
            ctrl_d.flag = 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i)
            ctrl_q <= '0;
        else
            ctrl_q <= ctrl_d;
    end

    assign ctrl_o  = ctrl_q;
    assign rdata_o = addr_hit ? REG_W'(ctrl_q) : '0;

endmodule

// File: rtl/pwt_count.sv
module pwt_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic             timeout_o
);

    logic [CNT_W-1:0] cnt_q;
    logic             half_q;
    logic             at_zero;

    assign at_zero   = (cnt_q == '0);
    assign timeout_o = run_i && tick_i && at_zero && half_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || !run_i) begin
            cnt_q  <= reload_i;
            half_q <= 1'b0;
        end else if (tick_i) begin
            if (at_zero) begin
                cnt_q  <= reload_i;
                half_q <= !half_q;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/pwt_wave.sv
module pwt_wave
    import pwt_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      run_i,
    input  logic      pin_en_i,
    input  pwt_wave_e mode_i,
    input  logic      tick_i,
    input  logic      timeout_i,
    output logic      pulse_o,
    output logic      toggle_o,
    output logic      wave_o
);

    logic pulse_q, toggle_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || !run_i) begin
            pulse_q  <= 1'b0;
            toggle_q <= 1'b0;
        end else begin
            if (timeout_i)
                pulse_q <= 1'b1;
            else if (tick_i)
                pulse_q <= 1'b0;
            if (timeout_i)
                toggle_q <= !toggle_q;
        end
    end

    assign pulse_o  = pulse_q;
    assign toggle_o = toggle_q;
    assign wave_o   = pin_en_i && run_i &&
                      ((mode_i == WAVE_CLOCK) ? toggle_q : pulse_q);

endmodule

// File: rtl/periodic_wakeup_timer.sv
module periodic_wakeup_timer
    import pwt_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int CTRL_ADDR = 2,
    parameter int CNT_W     = 16
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [7:0]        bus_wdata_i,
    input  logic              bus_we_i,
    output logic [7:0]        bus_rdata_o,
    input  logic [CNT_W-1:0]  reload_i,
    input  logic              auto_tick_i,
    input  logic              bus_tick_i,
    output logic              irq_o,
    output logic              ext_wave_o
);

    pwt_ctrl_t ctrl_q;
    logic      timeout, tick_sel, wr_hit, pulse_q, toggle_q;

    pwt_regs #(
        .ADDR_W    (ADDR_W),
        .CTRL_ADDR (CTRL_ADDR)
    ) u_regs (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .addr_i    (bus_addr_i),
        .wdata_i   (bus_wdata_i),
        .we_i      (bus_we_i),
        .timeout_i (timeout),
        .ctrl_o    (ctrl_q),
        .rdata_o   (bus_rdata_o),
        .wr_hit_o  (wr_hit)
    );

    assign tick_sel = (pwt_src_e'(ctrl_q.src_sel) == SRC_BUS) ? bus_tick_i : auto_tick_i;

    pwt_count #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .run_i     (ctrl_q.run),
        .tick_i    (tick_sel),
        .reload_i  (reload_i),
        .timeout_o (timeout)
    );

    pwt_wave u_wave (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .run_i     (ctrl_q.run),
        .pin_en_i  (ctrl_q.pin_en),
        .mode_i    (pwt_wave_e'(ctrl_q.wave_sel)),
        .tick_i    (tick_sel),
        .timeout_i (timeout),
        .pulse_o   (pulse_q),
        .toggle_o  (toggle_q),
        .wave_o    (ext_wave_o)
    );

    assign irq_o = ctrl_q.irq_en && ctrl_q.flag;

endmodule

// File: rtl/pwt_checker.sv
module pwt_checker
    import pwt_pkg::*;
(
    input logic      clk_i,
    input logic      rst_i,
    input pwt_ctrl_t ctrl,
    input logic      timeout,
    input logic      tick_sel,
    input logic      wr_hit,
    input logic      wdata0,
    input logic      pulse_q,
    input logic      toggle_q,
    input logic      irq_o,
    input logic      ext_wave_o
);

    // R3
    src_lock_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        ctrl.run |=> $stable(ctrl.src_sel));

    // R5
    flag_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(ctrl.flag) |-> $past(wr_hit && wdata0));

    // R6
    flag_set_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        timeout |=> ctrl.flag);

    // R4
    timeout_run_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        timeout |-> ctrl.run && tick_sel);

    // R8
    pulse_width_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        pulse_q && tick_sel |=> !pulse_q);

    // R9
    toggle_restart_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !ctrl.run |=> !toggle_q);

    // R7
    irq_gate_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_o |-> ctrl.flag);

    // R10
    pin_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        ext_wave_o |-> ctrl.pin_en && ctrl.run);

endmodule

bind periodic_wakeup_timer pwt_checker u_pwt_checker (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .ctrl       (ctrl_q),
    .timeout    (timeout),
    .tick_sel   (tick_sel),
    .wr_hit     (wr_hit),
    .wdata0     (bus_wdata_i[0]),
    .pulse_q    (pulse_q),
    .toggle_q   (toggle_q),
    .irq_o      (irq_o),
    .ext_wave_o (ext_wave_o)
);

// File: tb/periodic_wakeup_timer_bench.sv
module periodic_wakeup_timer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 4;
    localparam int CTRL_ADDR  = 2;
    localparam int CNT_W      = 16;

    logic              clk = 1'b0;
    logic              rst;
    logic [ADDR_W-1:0] addr;
    logic [7:0]        wdata;
    logic              we;
    logic [7:0]        rdata;
    logic [CNT_W-1:0]  reload;
    logic              atick, btick;
    logic              irq, wave;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = !clk;

    periodic_wakeup_timer #(
        .ADDR_W    (ADDR_W),
        .CTRL_ADDR (CTRL_ADDR),
        .CNT_W     (CNT_W)
    ) u_periodic_wakeup_timer (
        .clk_i       (clk),
        .rst_i       (rst),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_we_i    (we),
        .bus_rdata_o (rdata),
        .reload_i    (reload),
        .auto_tick_i (atick),
        .bus_tick_i  (btick),
        .irq_o       (irq),
        .ext_wave_o  (wave)
    );

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] d);
        @(negedge clk);
        wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic tick_auto(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); atick = 1'b1;
            @(negedge clk); atick = 1'b0;
        end
    endtask

    task automatic tick_bus(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); btick = 1'b1;
            @(negedge clk); btick = 1'b0;
        end
    endtask

    task automatic stop_all();
        wr(8'h01);
        wr(8'h00);
    endtask

    task automatic t_reset();
        check("R1 reset reg", rdata, 8'h00);
        check("R1 reset irq", irq, 0);
        check("R1 reset pin", wave, 0);
        wr(8'h60);
        check("R1 unused bits", rdata, 8'h00);
    endtask

    task automatic t_lock();
        wr(8'h80);
        check("R3 set while stopped", rdata, 8'h80);
        wr(8'h04);
        check("R3 start write keeps source", rdata, 8'h84);
        wr(8'h04);
        check("R3 running write locked", rdata, 8'h84);
        wr(8'h00);
        check("R3 stopping write locked", rdata, 8'h80);
        wr(8'h00);
        check("R3 cleared when stopped", rdata, 8'h00);
    endtask

    task automatic t_period();
        reload = 16'd2;
        wr(8'h04);
        tick_auto(3);
        tick_bus(3);
        tick_auto(2);
        check("R4 no timeout at 5 ticks", rdata, 8'h04);
        check("R2 bus tick ignored", rdata, 8'h04);
        tick_auto(1);
        check("R4 timeout at tick 6", rdata, 8'h05);
        wr(8'h05);
        tick_auto(5);
        check("R4 second period early", rdata, 8'h04);
        tick_auto(1);
        check("R4 second period", rdata, 8'h05);
        stop_all();
        wr(8'h04);
        tick_auto(5);
        check("R4 restart counts from start", rdata, 8'h04);
        stop_all();
    endtask

    task automatic t_bus_src();
        reload = 16'd0;
        wr(8'h80);
        wr(8'h84);
        tick_auto(4);
        check("R2 auto tick ignored", rdata, 8'h84);
        tick_bus(1);
        check("R2 bus one tick", rdata, 8'h84);
        tick_bus(1);
        check("R2 bus timeout", rdata, 8'h85);
        wr(8'h01);
        check("R3 stop keeps bus source", rdata, 8'h80);
        wr(8'h00);
    endtask

    task automatic t_w1c();
        reload = 16'd0;
        wr(8'h04);
        tick_auto(2);
        check("R5 flag set", rdata, 8'h05);
        wr(8'h04);
        check("R5 write 0 no effect", rdata, 8'h05);
        wr(8'h05);
        check("R5 write 1 clears", rdata, 8'h04);
        stop_all();
    endtask

    task automatic t_collide();
        reload = 16'd0;
        wr(8'h04);
        tick_auto(3);
        @(negedge clk);
        wdata = 8'h05; we = 1'b1; atick = 1'b1;
        @(negedge clk);
        we = 1'b0; atick = 1'b0;
        check("R6 timeout beats clear", rdata, 8'h05);
        wr(8'h05);
        check("R6 later clear works", rdata, 8'h04);
        stop_all();
    endtask

    task automatic t_irq();
        reload = 16'd0;
        wr(8'h06);
        check("R7 no flag no irq", irq, 0);
        tick_auto(2);
        check("R7 irq asserted", irq, 1);
        wr(8'h04);
        check("R7 irq masked", irq, 0);
        wr(8'h06);
        check("R7 irq re-enabled", irq, 1);
        wr(8'h07);
        check("R7 irq drops on clear", irq, 0);
        stop_all();
    endtask

    task automatic t_pulse();
        reload = 16'd1;
        wr(8'h0C);
        tick_auto(3);
        check("R8 low before end", wave, 0);
        tick_auto(1);
        check("R8 pulse high", wave, 1);
        @(negedge clk);
        check("R8 held between ticks", wave, 1);
        tick_auto(1);
        check("R8 pulse one tick", wave, 0);
        tick_auto(3);
        check("R8 second pulse", wave, 1);
        stop_all();
    endtask

    task automatic t_clock();
        reload = 16'd1;
        wr(8'h1C);
        check("R9 starts low", wave, 0);
        tick_auto(4);
        check("R9 high after first timeout", wave, 1);
        tick_auto(3);
        check("R9 held over period", wave, 1);
        tick_auto(1);
        check("R9 low after second timeout", wave, 0);
        tick_auto(4);
        check("R9 high again", wave, 1);
        wr(8'h18);
        check("R10 stopped pin low", wave, 0);
        wr(8'h1C);
        tick_auto(3);
        check("R9 restart low", wave, 0);
        tick_auto(1);
        check("R9 restart high", wave, 1);
        stop_all();
    endtask

    task automatic t_pin_off();
        reload = 16'd0;
        wr(8'h14);
        tick_auto(2);
        check("R10 clock mode pin off", wave, 0);
        stop_all();
        wr(8'h04);
        tick_auto(2);
        check("R10 pulse mode pin off", wave, 0);
        check("R10 timeout still seen", rdata, 8'h05);
        stop_all();
    endtask

    initial begin
        rst = 1'b1; addr = ADDR_W'(CTRL_ADDR); wdata = '0; we = 1'b0;
        reload = '0; atick = 1'b0; btick = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_lock();
        t_period();
        t_bus_src();
        t_w1c();
        t_collide();
        t_irq();
        t_pulse();
        t_clock();
        t_pin_off();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule